// File: doc/BRIEF.md
# Floating-Point Control Register Alias Views

This block holds the 32-bit floating-point control/status word of a processor core. Move-to and move-from control-register instructions reach it through a 5-bit index. Index 31 reaches the whole word. Three other indices are compact partial views. Each one gathers a few scattered fields of the word into a dense layout on a read. On a write it spreads the written bits back into their home positions. Every field a view does not cover keeps its value. Index 0 returns a read-only identification constant that is set by a parameter.

A read is combinational. While the read request is high, the selected view appears on the read data port in the same cycle. A write is committed on the next rising clock edge. An index with no defined view raises the illegal-index flag. So does a write to the read-only identification index. Neither case changes any state. No floating-point arithmetic lives here.

Top module: `fpu_ctl_views`

## Requirements
- R1: After a synchronous active-low reset, the status word is all zeros. A read at index 31 returns 0.
- R2: A write at index 31 replaces all 32 status bits on the next rising edge. A read at index 31 returns the whole word.
- R3: A read at index 0 returns the `ID_VALUE` parameter. A write at index 0 raises `illegal_idx` and leaves the status word unchanged.
- R4: A read at index 25 returns status bits 31:25 in data bits 7:1 and status bit 23 in data bit 0. All higher data bits are zero.
- R5: A write at index 25 loads status bits 31:25 from data bits 7:1. Status bits 24:0 are kept, including bit 23.
- R6: A read at index 26 returns status bits 17:12 and 6:2 in their own positions. All other bits are zero (mask 0x0003F07C).
- R7: A write at index 26 updates only status bits 17:12 and 6:2, each from the same data bit positions.
- R8: A read at index 28 returns status bits 11:7 and 1:0 in their own positions and status bit 24 in data bit 2. All other bits are zero.
- R9: A write at index 28 sets status bit 24 from data bit 2, status bits 11:7 from data bits 11:7, and status bits 1:0 from data bits 1:0. All other status bits are kept.
- R10: For any index other than 0, 25, 26, 28 and 31, a read or a write raises `illegal_idx` in the same cycle. Such a read returns 0. Such a write leaves the status word unchanged.
- R11: While `rd_req` is low, `rd_data` is 0. While neither `rd_req` nor `wr_en` is high, `illegal_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_idx | input | 5 | Control-register index for the access |
| wr_data | input | 32 | Data for a write access |
| wr_en | input | 1 | Write request, committed at the next rising edge |
| rd_req | input | 1 | Read request, data returned in the same cycle |
| rd_data | output | 32 | View selected by `reg_idx`; 0 when no read is requested |
| illegal_idx | output | 1 | Access to an undefined index, or a write to the read-only index |

## Verification
The assertions assume that `reg_idx`, `wr_en` and `wr_data` are steady and free of X values around each rising edge. The bench meets this by changing inputs only on the falling edge. The hold checks for partial writes also assume that one write request is a single access, so no other update competes with it. The bench therefore raises `wr_en` for exactly one edge per write. It never raises it together with a read whose result it checks.

// File: rtl/fcv_pkg.sv
// Package: shared widths, index codes and the view-kind type for the
// floating-point control register alias views.
// Assumes a 32-bit status word and a 5-bit index space.
package fcv_pkg;
    localparam int IDX_W  = 5;
    localparam int WORD_W = 32;

    // index codes that select a view
    localparam logic [IDX_W-1:0] IDX_IDENT = 5'd0;
    localparam logic [IDX_W-1:0] IDX_CC    = 5'd25;
    localparam logic [IDX_W-1:0] IDX_EXC   = 5'd26;
    localparam logic [IDX_W-1:0] IDX_ENA   = 5'd28;
    localparam logic [IDX_W-1:0] IDX_FULL  = 5'd31;

    // status fields covered by the exception view
    localparam logic [WORD_W-1:0] EXC_MASK = 32'h0003_F07C;

    typedef enum logic [2:0] {
        VIEW_NONE,
        VIEW_IDENT,
        VIEW_CC,
        VIEW_EXC,
        VIEW_ENA,
        VIEW_FULL
    } view_e;
endpackage

// File: rtl/fcv_index_decode.sv
// Module: maps the register index onto a view kind and raises the
// illegal flag for undefined indices or writes to the read-only one.
// Assumes wr_en and rd_req are single-cycle qualified requests.
module fcv_index_decode
    import fcv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] reg_idx,
    input  logic             wr_en,
    input  logic             rd_req,
    output view_e            view,
    output logic             wr_ok,
    output logic             illegal
);
    logic rd_ok;

    // Map the index code onto a view kind
    always_comb begin
        case (reg_idx)
            IDX_IDENT: view = VIEW_IDENT;
            IDX_CC:    view = VIEW_CC;
            IDX_EXC:   view = VIEW_EXC;
            IDX_ENA:   view = VIEW_ENA;
            IDX_FULL:  view = VIEW_FULL;
            default:   view = VIEW_NONE;
        endcase
    end

    // Qualify requests and flag unsupported ones
    always_comb begin
        rd_ok   = (view != VIEW_NONE);
        wr_ok   = wr_en && (view != VIEW_NONE) && (view != VIEW_IDENT);
        illegal = (rd_req && !rd_ok) || (wr_en && !wr_ok);
    end

    // R11
    idle_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_req && !wr_en) |-> !illegal);

    // R3
    ident_write_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_idx == IDX_IDENT) |-> (illegal && !wr_ok));
endmodule

// File: rtl/fcv_status_reg.sv
// Module: stores the status word and merges each view's write back
// into the scattered field positions, keeping unaddressed fields.
// Assumes wr_ok is already qualified by the index decoder.
module fcv_status_reg
    import fcv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  view_e             view,
    input  logic              wr_ok,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] status
);
    logic [WORD_W-1:0] merged;

    // Build the next status word for the selected view
    always_comb begin
        merged = status;
        case (view)
            VIEW_FULL: merged = wr_data;
            VIEW_CC:   merged[31:25] = wr_data[7:1];
            VIEW_EXC: begin
                merged[17:12] = wr_data[17:12];
                merged[6:2]   = wr_data[6:2];
            end
            VIEW_ENA: begin
                merged[24]   = wr_data[2];
                merged[11:7] = wr_data[11:7];
                merged[1:0]  = wr_data[1:0];
            end
            default: merged = status;
        endcase
    end

    // Commit the merged word on a qualified write
    always_ff @(posedge clk) begin
        if (!rst_n)
            status <= '0;
        else if (wr_ok)
            status <= merged;
    end

    // R10
    blocked_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ok |=> $stable(status));

    // R5
    cc_write_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && view == VIEW_CC) |=> (status[24:0] == $past(status[24:0])));

    // R7
    exc_write_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && view == VIEW_EXC) |=>
            (status[31:18] == $past(status[31:18]) &&
             status[11:7]  == $past(status[11:7])  &&
             status[1:0]   == $past(status[1:0])));

    // R9
    ena_write_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && view == VIEW_ENA) |=>
            (status[31:25] == $past(status[31:25]) &&
             status[23:12] == $past(status[23:12]) &&
             status[6:2]   == $past(status[6:2])));
endmodule

// File: rtl/fcv_read_pack.sv
// Module: packs the scattered status fields into the compact layout of
// the selected view; drives zero when no read is requested.
// Assumes the index decoder reports undefined indices as VIEW_NONE.
module fcv_read_pack
    import fcv_pkg::*;
#(
    parameter logic [WORD_W-1:0] ID_VALUE = 32'h0001_0300
)(
    input  logic              clk,
    input  logic              rst_n,
    input  view_e             view,
    input  logic              rd_req,
    input  logic [WORD_W-1:0] status,
    output logic [WORD_W-1:0] rd_data
);
    // Gather the fields of the selected view
    always_comb begin
        rd_data = '0;
        if (rd_req) begin
            case (view)
                VIEW_IDENT: rd_data = ID_VALUE;
                VIEW_FULL:  rd_data = status;
                VIEW_CC:    rd_data[7:0] = {status[31:25], status[23]};
                VIEW_EXC:   rd_data = status & EXC_MASK;
                VIEW_ENA: begin
                    rd_data[11:7] = status[11:7];
                    rd_data[2]    = status[24];
                    rd_data[1:0]  = status[1:0];
                end
                default:    rd_data = '0;
            endcase
        end
    end

    // R11
    no_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |-> (rd_data == '0));

    // R4
    cc_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && view == VIEW_CC) |-> (rd_data[31:8] == '0));
endmodule

// File: rtl/fpu_ctl_views.sv
// Module: top of the floating-point control register alias views;
// ties the index decoder, status storage and read packer together.
// Assumes inputs are stable around the rising clock edge.
module fpu_ctl_views
    import fcv_pkg::*;
#(
    parameter logic [WORD_W-1:0] ID_VALUE = 32'h0001_0300
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              wr_en,
    input  logic              rd_req,
    output logic [WORD_W-1:0] rd_data,
    output logic              illegal_idx
);
    view_e             view;
    logic              wr_ok;
    logic [WORD_W-1:0] status;

    fcv_index_decode u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .reg_idx (reg_idx),
        .wr_en   (wr_en),
        .rd_req  (rd_req),
        .view    (view),
        .wr_ok   (wr_ok),
        .illegal (illegal_idx)
    );

    fcv_status_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .view    (view),
        .wr_ok   (wr_ok),
        .wr_data (wr_data),
        .status  (status)
    );

    fcv_read_pack #(.ID_VALUE(ID_VALUE)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .view    (view),
        .rd_req  (rd_req),
        .status  (status),
        .rd_data (rd_data)
    );
endmodule

// File: tb/fpu_ctl_views_tb.sv
`timescale 1ns/1ps
module fpu_ctl_views_tb_top;
    localparam logic [31:0] ID = 32'h0001_0300;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  reg_idx = '0;
    logic [31:0] wr_data = '0;
    logic        wr_en = 1'b0;
    logic        rd_req = 1'b0;
    logic [31:0] rd_data;
    logic        illegal_idx;

    int tests = 0;
    int fails = 0;
    logic [31:0] model = '0;

    always #5 clk = ~clk;

    fpu_ctl_views #(.ID_VALUE(ID)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .wr_data(wr_data),
        .wr_en(wr_en), .rd_req(rd_req), .rd_data(rd_data),
        .illegal_idx(illegal_idx)
    );

    task automatic check(input string req, input logic [31:0] got,
                         input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    // Read one index; check data and flag
    task automatic rd(input logic [4:0] idx, input logic [31:0] exp,
                      input logic exp_bad, input string req);
        @(negedge clk);
        reg_idx = idx; rd_req = 1'b1;
        #1;
        check(req, rd_data, exp);
        check(req, {31'b0, illegal_idx}, {31'b0, exp_bad});
        @(negedge clk);
        rd_req = 1'b0;
    endtask

    // Write one index for exactly one edge; check flag
    task automatic wr(input logic [4:0] idx, input logic [31:0] d,
                      input logic exp_bad, input string req);
        @(negedge clk);
        reg_idx = idx; wr_data = d; wr_en = 1'b1;
        #1;
        check(req, {31'b0, illegal_idx}, {31'b0, exp_bad});
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [31:0] cc_view(input logic [31:0] s);
        return {24'b0, s[31:25], s[23]};
    endfunction
    function automatic logic [31:0] ena_view(input logic [31:0] s);
        return {20'b0, s[11:7], 4'b0, s[24], s[1:0]};
    endfunction

    task automatic t_reset;
        rd(5'd31, 32'h0, 1'b0, "R1 reset word");
        @(negedge clk); #1;
        check("R11 idle data", rd_data, 32'h0);
        check("R11 idle flag", {31'b0, illegal_idx}, 32'h0);
    endtask

    task automatic t_full;
        wr(5'd31, 32'hA5A5_5A5A, 1'b0, "R2 write flag");
        model = 32'hA5A5_5A5A;
        rd(5'd31, model, 1'b0, "R2 full read");
        wr(5'd31, 32'hFFFF_FFFF, 1'b0, "R2 write flag");
        model = 32'hFFFF_FFFF;
        rd(5'd31, model, 1'b0, "R2 all ones");
    endtask

    task automatic t_ident;
        rd(5'd0, ID, 1'b0, "R3 ident read");
        wr(5'd0, 32'h1234_5678, 1'b1, "R3 ident write flag");
        rd(5'd31, model, 1'b0, "R3 word unchanged");
    endtask

    task automatic t_cc;
        wr(5'd31, 32'h0080_0000, 1'b0, "R2 setup");
        model = 32'h0080_0000;
        rd(5'd25, 32'h0000_0001, 1'b0, "R4 cc bit0 from status 23");
        wr(5'd31, 32'hAB7F_FFFF, 1'b0, "R2 setup");
        model = 32'hAB7F_FFFF;
        rd(5'd25, cc_view(model), 1'b0, "R4 cc view");
        wr(5'd25, 32'hFFFF_FF55, 1'b0, "R5 cc write flag");
        model[31:25] = 7'b0101010;
        rd(5'd31, model, 1'b0, "R5 cc write merge");
        rd(5'd25, 32'h0000_0054, 1'b0, "R4 cc view after write");
    endtask

    task automatic t_exc;
        wr(5'd31, 32'hFFFF_FFFF, 1'b0, "R2 setup");
        model = 32'hFFFF_FFFF;
        rd(5'd26, 32'h0003_F07C, 1'b0, "R6 exc mask");
        wr(5'd26, 32'h0000_0000, 1'b0, "R7 exc write flag");
        model = 32'hFFFC_0F83;
        rd(5'd31, model, 1'b0, "R7 exc clear merge");
        wr(5'd26, 32'hFFFF_FFFF, 1'b0, "R7 exc write flag");
        model = 32'hFFFF_FFFF;
        rd(5'd31, model, 1'b0, "R7 exc set merge");
    endtask

    task automatic t_ena;
        wr(5'd31, 32'h0100_0F83, 1'b0, "R2 setup");
        model = 32'h0100_0F83;
        rd(5'd28, 32'h0000_0F87, 1'b0, "R8 ena view");
        wr(5'd31, 32'hFEFF_F07C, 1'b0, "R2 setup");
        model = 32'hFEFF_F07C;
        rd(5'd28, ena_view(model), 1'b0, "R8 ena view complement");
        wr(5'd28, 32'hFFFF_FFFF, 1'b0, "R9 ena write flag");
        model = 32'hFFFF_FFFF;
        rd(5'd31, model, 1'b0, "R9 ena set merge");
        wr(5'd28, 32'h0000_0281, 1'b0, "R9 ena write flag");
        model[24] = 1'b0; model[11:7] = 5'b00101; model[1:0] = 2'b01;
        rd(5'd31, model, 1'b0, "R9 ena pattern merge");
    endtask

    task automatic t_illegal;
        logic [31:0] keep;
        keep = model;
        rd(5'd5, 32'h0, 1'b1, "R10 read idx5");
        rd(5'd27, 32'h0, 1'b1, "R10 read idx27");
        rd(5'd30, 32'h0, 1'b1, "R10 read idx30");
        wr(5'd1, 32'h0000_0000, 1'b1, "R10 write idx1");
        wr(5'd29, 32'h0000_0000, 1'b1, "R10 write idx29");
        rd(5'd31, keep, 1'b0, "R10 word unchanged");
    endtask

    task automatic t_reset_again;
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        model = '0;
        rd(5'd31, 32'h0, 1'b0, "R1 reset clears word");
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_full();
        t_ident();
        t_cc();
        t_exc();
        t_ena();
        t_illegal();
        t_reset_again();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule